// File: doc/BRIEF.md
# Flash Block Blank-Check Scanner

This engine decides whether one block of a flash array model is fully erased. Software starts it with a two-write command sequence. The first write carries the setup code. The second write carries the confirm code and an address inside the target block. The engine then reads each word of that block through a combinational array read port, one word per clock, from the lowest address of the block upward. It leaves its verdict in an 8-bit status word.

Bit 7 of the status word is the ready flag. It reads 0 while a scan runs and 1 otherwise. Bit 5 is the fail flag, which is raised when a scanned word is not all ones. Bits 5 and 4 together signal a malformed command sequence. Both error bits hold their value until a clear command removes them. A mode output shows whether reads of the device would return status (1) or array data (0).

A scan cannot be suspended or interrupted. While it runs, every command write is dropped.

Top module: `blank_scan`

## Requirements
- R1: After reset, `status` is 8'h80, `stat_mode` is 0 and `rd_en` is 0.
- R2: A write of 8'hBC followed by a write of 8'hD0 starts a scan. `status[7]` reads 0 from the cycle after the confirm write, and `stat_mode` reads 1 from the cycle after the setup write.
- R3: While scanning, `rd_en` is 1 and `rd_addr` steps by one each cycle. It starts at the confirm address with its low BLK_LOG2 bits cleared and covers at most 2**BLK_LOG2 words.
- R4: When every word of the block equals all ones, the scan lasts exactly 2**BLK_LOG2 cycles and ends with `status[7]`=1 and `status[5]`=0.
- R5: At the first word that is not all ones, the scan stops. That word is the last one read, and `status` then shows bits 7 and 5 set.
- R6: A write of 8'hBC followed by any second write other than 8'hD0 sets `status[5]` and `status[4]`, starts no scan and issues no array read.
- R7: Every command write that arrives while a scan runs is ignored, including 8'hB0, 8'hD0, 8'h50 and 8'hBC.
- R8: `status[5]` and `status[4]` stay set across later scans and other commands until an idle write of 8'h50 clears both. `status[3:0]` and `status[6]` always read 0.
- R9: An idle write of 8'hFF sets `stat_mode` to 0 and leaves the status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command write strobe, one cycle per write |
| cmd_addr | input | ADDR_W | Word address accompanying the command |
| cmd_data | input | 8 | Command code |
| rd_en | output | 1 | Array read request, high during a scan |
| rd_addr | output | ADDR_W | Array word address being checked |
| rd_data | input | DATA_W | Array word at `rd_addr`, same cycle |
| status | output | 8 | Status word: ready, fail, sequence error |
| stat_mode | output | 1 | 1 when reads return status, 0 for array data |

## Verification
Two events can meet in one cycle: a command write that arrives while the scan is still stepping, and the scan's own final word. The bench issues confirm, clear, suspend and setup writes in the cycles right after a scan starts. One scan fails on its last word, so the fail flag and the end of the scan come together. A behavioural reference model, stepped on every clock edge, predicts the status word, mode, read strobe and address. The design is compared against it each cycle, with directed checks on read counts and final status.

// File: rtl/blank_scan.sv
module blank_scan #(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 16,
  parameter int BLK_LOG2    = 4,
  parameter logic [7:0] CMD_SETUP   = 8'hBC,
  parameter logic [7:0] CMD_CONFIRM = 8'hD0,
  parameter logic [7:0] CMD_CLEAR   = 8'h50,
  parameter logic [7:0] CMD_READ    = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic [7:0]        status,
  output logic              stat_mode
);

  localparam int BASE_W = ADDR_W - BLK_LOG2;

  logic                busy, armed, mode, sr5, sr4;
  logic [BASE_W-1:0]   blk;
  logic [BLK_LOG2-1:0] idx;

  wire word_bad = busy && (rd_data != {DATA_W{1'b1}});
  wire last     = (idx == {BLK_LOG2{1'b1}});
  wire idle_we  = cmd_we && !busy;

  assign rd_en     = busy;
  assign rd_addr   = {blk, idx};
  assign status    = {~busy, 1'b0, sr5, sr4, 4'b0000};
  assign stat_mode = mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      armed <= 1'b0;
      mode  <= 1'b0;
      sr5   <= 1'b0;
      sr4   <= 1'b0;
      blk   <= '0;
      idx   <= '0;
    end else if (busy) begin
      idx <= idx + 1'b1;
      if (word_bad) begin
        sr5  <= 1'b1;
        busy <= 1'b0;
      end else if (last) begin
        busy <= 1'b0;
      end
    end else if (cmd_we) begin
      if (armed) begin
        armed <= 1'b0;
        if (cmd_data == CMD_CONFIRM) begin
          busy <= 1'b1;
          mode <= 1'b1;
          blk  <= cmd_addr[ADDR_W-1:BLK_LOG2];
          idx  <= '0;
        end else begin
          sr5 <= 1'b1;
          sr4 <= 1'b1;
        end
      end else begin
        case (cmd_data)
          CMD_SETUP: begin armed <= 1'b1; mode <= 1'b1; end
          CMD_CLEAR: begin sr5 <= 1'b0; sr4 <= 1'b0; end
          CMD_READ:  mode <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  // R3: address advances by one word while the scan continues
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last && !word_bad) |=> (rd_en && rd_addr == $past(rd_addr) + 1'b1));

  // R4: the final word of a clean block ends the scan
  a_r4_ends_at_last: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last) |=> (status[7] && !rd_en));

  // R5: a bad word stops the scan and flags failure
  a_r5_stop_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
    word_bad |=> (status[7] && status[5] && !rd_en));

  // R6: wrong second write flags a sequence error
  a_r6_seq_error: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_we && armed && cmd_data != CMD_CONFIRM) |=> (status[5] && status[4] && !rd_en));

  // R7: writes during a scan leave mode and error bit alone
  a_r7_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_we) |=> ($stable(stat_mode) && $stable(status[4]) && !armed));

  // R8: error bits are sticky until a clear command
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status[4] && !(idle_we && !armed && cmd_data == CMD_CLEAR)) |=> status[4]);

endmodule

// File: tb/blank_scan_tb.sv
module blank_scan_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int BL = 4;
  localparam int NW = 1 << BL;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          cmd_we = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0]    cmd_data = '0;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic [7:0]    status;
  logic          stat_mode;

  logic [DW-1:0] mem [0:(1<<AW)-1];
  assign rd_data = mem[rd_addr];

  int n_chk = 0, n_fail = 0, rd_cnt = 0;
  bit done = 0;

  // reference model state
  bit m_busy, m_arm, m_mode, m_sr5, m_sr4;
  int m_base, m_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  blank_scan #(.ADDR_W(AW), .DATA_W(DW), .BLK_LOG2(BL)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .status(status), .stat_mode(stat_mode));

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_arm = 0; m_mode = 0; m_sr5 = 0; m_sr4 = 0;
      m_base = 0; m_idx = 0;
    end else if (m_busy) begin
      if (mem[m_base*NW + m_idx] != 16'hFFFF) begin
        m_sr5 = 1; m_busy = 0;
      end else if (m_idx == NW-1) m_busy = 0;
      m_idx = (m_idx + 1) % NW;
    end else if (cmd_we) begin
      if (m_arm) begin
        m_arm = 0;
        if (cmd_data == 8'hD0) begin
          m_busy = 1; m_mode = 1; m_base = cmd_addr / NW; m_idx = 0;
        end else begin
          m_sr5 = 1; m_sr4 = 1;
        end
      end else if (cmd_data == 8'hBC) begin m_arm = 1; m_mode = 1; end
      else if (cmd_data == 8'h50) begin m_sr5 = 0; m_sr4 = 0; end
      else if (cmd_data == 8'hFF) m_mode = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 ready bit", status[7], !m_busy);
      check("R8 error bits", status[6:0], {1'b0, m_sr5, m_sr4, 4'b0});
      check("R9 mode", stat_mode, m_mode);
      check("R3 read strobe", rd_en, m_busy);
      if (rd_en) begin
        rd_cnt++;
        check("R3 read address", rd_addr, m_base*NW + m_idx);
      end
    end
  end

  task automatic wr(logic [7:0] c, logic [AW-1:0] a);
    @(negedge clk);
    cmd_we = 1; cmd_data = c; cmd_addr = a;
    @(negedge clk);
    cmd_we = 0;
  endtask

  task automatic wait_ready();
    while (!status[7]) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < (1<<AW); i++) mem[i] = 16'hFFFF;
    mem[2*NW + 5]  = 16'hFFFE;
    mem[3*NW + 15] = 16'h7FFF;
    mem[5*NW + 0]  = 16'h0000;
    #(CLK_PERIOD*2 + 2);
    check("R1 status", status, 8'h80);
    check("R1 mode", stat_mode, 0);
    check("R1 read strobe", rd_en, 0);
    @(negedge clk); rst_n = 1;

    // R4 clean block, confirm address mid-block
    rd_cnt = 0;
    wr(8'hBC, 8'h13); check("R2 mode after setup", stat_mode, 1);
    wr(8'hD0, 8'h1B); check("R2 busy after confirm", status[7], 0);
    wait_ready();
    check("R4 read count", rd_cnt, NW);
    check("R4 status", status, 8'h80);

    // R7 writes during a scan
    rd_cnt = 0;
    wr(8'hBC, 8'h40); wr(8'hD0, 8'h40);
    wr(8'hB0, 8'h40); wr(8'hD0, 8'h40); wr(8'h50, 8'h40); wr(8'hBC, 8'h40);
    wait_ready();
    check("R7 scan unaffected", rd_cnt, NW);
    rd_cnt = 0;
    wr(8'hD0, 8'h40);
    repeat (2) @(negedge clk);
    check("R7 setup during scan not armed", rd_cnt, 0);
    check("R7 status", status, 8'h80);

    // R5 fail mid-block
    rd_cnt = 0;
    wr(8'hBC, 8'h20); wr(8'hD0, 8'h20); wait_ready();
    check("R5 reads until bad word", rd_cnt, 6);
    check("R5 status", status, 8'hA0);
    wr(8'h50, 8'h00);
    check("R8 clear", status, 8'h80);

    // R6 sequence error, R9 read array, R8 sticky
    rd_cnt = 0;
    wr(8'hBC, 8'h30); wr(8'hFF, 8'h30);
    check("R6 status", status, 8'hB0);
    check("R6 no reads", rd_cnt, 0);
    wr(8'hFF, 8'h00);
    check("R9 mode cleared", stat_mode, 0);
    check("R8 sticky over read", status, 8'hB0);
    wr(8'hBC, 8'h10); wr(8'hD0, 8'h10); wait_ready();
    check("R8 sticky over scan", status, 8'hB0);
    wr(8'h50, 8'h00);
    check("R8 cleared", status, 8'h80);

    // R5 fail on last word, then on first word
    rd_cnt = 0;
    wr(8'hBC, 8'h3F); wr(8'hD0, 8'h30); wait_ready();
    check("R5 last word reads", rd_cnt, NW);
    check("R5 last word status", status, 8'hA0);
    wr(8'h50, 8'h00);
    rd_cnt = 0;
    wr(8'hBC, 8'h55); wr(8'hD0, 8'h55); wait_ready();
    check("R5 first word reads", rd_cnt, 1);
    check("R5 first word status", status, 8'hA0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule